// File: doc/BRIEF.md
# Static Not-Taken Branch Redirect and Squash Unit

This unit handles control hazards in a five-stage in-order pipeline that uses static not-taken prediction. Fetch always moves on to the next sequential word. A conditional branch resolves in the execute stage. There the unit compares the two register operands and forms the branch target. When the branch is taken, the unit steers the program counter to the target. It also turns the two younger instructions, which sit in the fetch and decode stages, into bubbles.

The unit keeps its own live/dead record of the decode and execute slots. A squashed instruction therefore cannot redirect fetch when it later reaches execute. Its register-write and memory-write enables are dropped before they can reach the ID/EX register. The unit also settles the case where a load-use stall request and a taken branch arrive in the same cycle. The reset input is asserted asynchronously and released on a clock edge through a two-stage synchronizer.

Top module: `branch_flush_ctrl`

## Requirements
- R1: When no redirect occurs, `next_pc` equals `if_pc + 4` and `pc_sel`, `flush_if` and `flush_id` are 0.
- R2: A branch in execute meets its condition when `ex_kind` is 0 (equal test) and `ex_opa == ex_opb`, or when `ex_kind` is 1 (not-equal test) and the operands differ.
- R3: The redirect target is `ex_pc + 4 + (sign-extended ex_off << 2)`, and this holds for negative offsets too.
- R4: A live branch in execute whose condition is met drives `pc_sel`, `flush_if` and `flush_id` to 1 in the same cycle, and `next_pc` carries the target.
- R5: After a redirect, the execute slot holds squashed work for exactly two cycles. A branch presented in execute during those two cycles does not redirect, and one presented in the third cycle does.
- R6: A branch whose condition is not met causes no flush, and a live branch in execute in the very next cycle can redirect.
- R7: `ex_reg_we` and `ex_mem_we` are 0 in a redirect cycle and in the cycle after it, whatever `id_reg_we` and `id_mem_we` are. Two cycles after a redirect they follow the inputs again.
- R8: When `stall_req` and a redirect coincide, the redirect wins: `stall_out` is 0, `pc_en` is 1 and `next_pc` is the target.
- R9: A stall with no redirect gives `stall_out` = 1 and `pc_en` = 0. The execute slot becomes a bubble that cannot redirect in the next cycle, while the decode slot keeps its instruction.
- R10: During reset, and in the first cycles after release before the slots have filled, no redirect and no write enable are issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously |
| stall_req | input | 1 | Load-use stall request from the hazard detector |
| if_pc | input | 32 | Address of the instruction in fetch |
| ex_br | input | 1 | Execute stage holds a conditional branch |
| ex_kind | input | 1 | Branch test: 0 equal, 1 not equal |
| ex_opa | input | 32 | First compare operand |
| ex_opb | input | 32 | Second compare operand |
| ex_pc | input | 32 | Address of the branch in execute |
| ex_off | input | 16 | Signed word offset of the branch |
| id_reg_we | input | 1 | Register-write enable decoded in decode |
| id_mem_we | input | 1 | Memory-write enable decoded in decode |
| pc_sel | output | 1 | 1 selects the branch target for the next PC |
| next_pc | output | 32 | Next fetch address |
| pc_en | output | 1 | PC register load enable |
| stall_out | output | 1 | Stall passed to the IF/ID and PC registers |
| flush_if | output | 1 | Load a bubble into IF/ID |
| flush_id | output | 1 | Load a bubble into ID/EX |
| ex_reg_we | output | 1 | Register-write enable entering ID/EX |
| ex_mem_we | output | 1 | Memory-write enable entering ID/EX |

## Verification
The redirect, flush, stall and write-enable outputs are combinational in the current inputs and the slot state. Each check therefore drives its inputs on the falling edge and samples one time unit later in the same cycle. The slot state changes only on a rising edge. The penalty, bubble and enable-recovery checks count the rising edges after the stimulus: squashed work is due in the first and second following cycles, and live work again in the third. The reset checks sample while the synchronizer and both slots are still empty.

// File: rtl/bfc_pkg.sv
package bfc_pkg;
  typedef enum logic {
    BR_EQ = 1'b0,
    BR_NE = 1'b1
  } br_kind_e;
endpackage

// File: rtl/bfc_rst_sync.sv
module bfc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_s
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb sync_d = {sync_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_s = sync_q[STAGES-1];
endmodule

// File: rtl/bfc_resolve.sv
module bfc_resolve
  import bfc_pkg::*;
#(
  parameter int XLEN        = 32,
  parameter int OFFW        = 16,
  parameter int INSTR_BYTES = 4
) (
  input  br_kind_e          kind,
  input  logic [XLEN-1:0]   opa,
  input  logic [XLEN-1:0]   opb,
  input  logic [XLEN-1:0]   br_pc,
  input  logic [OFFW-1:0]   off,
  output logic              cond_met,
  output logic [XLEN-1:0]   target
);
  localparam int SHW = $clog2(INSTR_BYTES);
  localparam logic [XLEN-1:0] STEP = XLEN'(INSTR_BYTES);

  logic            same;
  logic [XLEN-1:0] off_sx;
  logic [XLEN-1:0] off_bytes;

  always_comb begin
    same      = (opa == opb);
    off_sx    = {{(XLEN-OFFW){off[OFFW-1]}}, off};
    off_bytes = off_sx << SHW;
    target    = br_pc + STEP + off_bytes;
    unique case (kind)
      BR_EQ:   cond_met = same;
      BR_NE:   cond_met = !same;
      default: cond_met = 1'b0;
    endcase
  end
endmodule

// File: rtl/bfc_slot_track.sv
module bfc_slot_track (
  input  logic clk,
  input  logic rst_s,
  input  logic taken,
  input  logic stall,
  output logic live_id,
  output logic live_ex
);
  logic id_en, id_nx, ex_nx;

  always_comb begin
    id_en = taken | ~stall;
    id_nx = ~taken;
    ex_nx = live_id & ~taken & ~stall;
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      live_id <= 1'b0;
      live_ex <= 1'b0;
    end else begin
      if (id_en) live_id <= id_nx;
      live_ex <= ex_nx;
    end
  end

  // R5: both younger slots are dead right after a redirect
  a_r5_squash_both: assert property (@(posedge clk) disable iff (!rst_s)
    taken |=> (!live_id && !live_ex));

  // R9: a stall bubbles execute and keeps decode
  a_r9_stall_bubble: assert property (@(posedge clk) disable iff (!rst_s)
    (stall && !taken) |=> (!live_ex && (live_id == $past(live_id))));
endmodule

// File: rtl/branch_flush_ctrl.sv
module branch_flush_ctrl
  import bfc_pkg::*;
#(
  parameter int XLEN        = 32,
  parameter int OFFW        = 16,
  parameter int INSTR_BYTES = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            stall_req,
  input  logic [XLEN-1:0] if_pc,
  input  logic            ex_br,
  input  logic            ex_kind,
  input  logic [XLEN-1:0] ex_opa,
  input  logic [XLEN-1:0] ex_opb,
  input  logic [XLEN-1:0] ex_pc,
  input  logic [OFFW-1:0] ex_off,
  input  logic            id_reg_we,
  input  logic            id_mem_we,
  output logic            pc_sel,
  output logic [XLEN-1:0] next_pc,
  output logic            pc_en,
  output logic            stall_out,
  output logic            flush_if,
  output logic            flush_id,
  output logic            ex_reg_we,
  output logic            ex_mem_we
);
  localparam logic [XLEN-1:0] STEP = XLEN'(INSTR_BYTES);

  logic            rst_s;
  logic            cond_met;
  logic [XLEN-1:0] tgt;
  logic            live_id, live_ex;
  logic            taken;
  logic            pass_id;

  bfc_rst_sync #(.STAGES(2)) u_rsync (
    .clk   (clk),
    .rst_n (rst_n),
    .rst_s (rst_s)
  );

  bfc_resolve #(.XLEN(XLEN), .OFFW(OFFW), .INSTR_BYTES(INSTR_BYTES)) u_res (
    .kind     (br_kind_e'(ex_kind)),
    .opa      (ex_opa),
    .opb      (ex_opb),
    .br_pc    (ex_pc),
    .off      (ex_off),
    .cond_met (cond_met),
    .target   (tgt)
  );

  bfc_slot_track u_trk (
    .clk     (clk),
    .rst_s   (rst_s),
    .taken   (taken),
    .stall   (stall_req),
    .live_id (live_id),
    .live_ex (live_ex)
  );

  always_comb begin
    taken     = ex_br & live_ex & cond_met;
    pass_id   = live_id & ~taken & ~stall_req;
    pc_sel    = taken;
    next_pc   = taken ? tgt : (if_pc + STEP);
    stall_out = stall_req & ~taken;
    pc_en     = ~stall_out;
    flush_if  = taken;
    flush_id  = taken;
    ex_reg_we = id_reg_we & pass_id;
    ex_mem_we = id_mem_we & pass_id;
  end

  // R5: a redirect is never followed by another in the next cycle
  a_r5_single_redirect: assert property (@(posedge clk) disable iff (!rst_s)
    pc_sel |=> !pc_sel);

  // R7: the instruction squashed out of fetch carries no write enables
  a_r7_squashed_no_write: assert property (@(posedge clk) disable iff (!rst_s)
    pc_sel |=> (!ex_reg_we && !ex_mem_we));

  // R8: flush beats stall
  a_r8_flush_wins: assert property (@(posedge clk) disable iff (!rst_s)
    (stall_req && pc_sel) |-> (pc_en && !stall_out));

  // R1: sequential path when no redirect
  a_r1_seq_path: assert property (@(posedge clk) disable iff (!rst_s)
    !pc_sel |-> (next_pc == if_pc + STEP));

  // R10: nothing issued while reset is held
  a_r10_quiet_reset: assert property (@(posedge clk)
    !rst_s |-> (!pc_sel && !ex_reg_we && !ex_mem_we));
endmodule

// File: tb/branch_flush_ctrl_test.sv
module branch_flush_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        stall_req, ex_br, ex_kind, id_reg_we, id_mem_we;
  logic [31:0] if_pc, ex_opa, ex_opb, ex_pc;
  logic [15:0] ex_off;
  logic        pc_sel, pc_en, stall_out, flush_if, flush_id, ex_reg_we, ex_mem_we;
  logic [31:0] next_pc;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  branch_flush_ctrl uut (
    .clk(clk), .rst_n(rst_n), .stall_req(stall_req), .if_pc(if_pc),
    .ex_br(ex_br), .ex_kind(ex_kind), .ex_opa(ex_opa), .ex_opb(ex_opb),
    .ex_pc(ex_pc), .ex_off(ex_off), .id_reg_we(id_reg_we), .id_mem_we(id_mem_we),
    .pc_sel(pc_sel), .next_pc(next_pc), .pc_en(pc_en), .stall_out(stall_out),
    .flush_if(flush_if), .flush_id(flush_id), .ex_reg_we(ex_reg_we), .ex_mem_we(ex_mem_we)
  );

  function automatic logic [31:0] exp_tgt(input logic [31:0] pc, input logic [15:0] off);
    return pc + 32'd4 + ({{16{off[15]}}, off} << 2);
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic quiet();
    stall_req = 0; ex_br = 0; ex_kind = 0; ex_opa = 0; ex_opb = 0;
    ex_pc = 32'h0; ex_off = 16'h0; id_reg_we = 0; id_mem_we = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin cyc(); quiet(); end
  endtask

  task automatic put_br(input logic kind, input logic [31:0] a, input logic [31:0] b,
                        input logic [31:0] pc, input logic [15:0] off);
    ex_br = 1; ex_kind = kind; ex_opa = a; ex_opb = b; ex_pc = pc; ex_off = off;
  endtask

  task automatic t_reset();
    rst_n = 0; quiet(); if_pc = 32'h40;
    put_br(1'b0, 32'd7, 32'd7, 32'h80, 16'h4); id_reg_we = 1; id_mem_we = 1;
    repeat (3) cyc();
    #1;
    chk("R10", "pc_sel in reset", pc_sel, 0);
    chk("R10", "ex_reg_we in reset", ex_reg_we, 0);
    chk("R10", "ex_mem_we in reset", ex_mem_we, 0);
    chk("R1", "next_pc in reset", next_pc, 32'h44);
    rst_n = 1;
    for (int i = 0; i < 2; i++) begin
      cyc(); #1;
      chk("R10", "pc_sel after release", pc_sel, 0);
    end
    idle(4);
  endtask

  task automatic t_seq();
    logic [31:0] pcs [3] = '{32'h0, 32'h1000, 32'hFFFF_FFFC};
    for (int i = 0; i < 3; i++) begin
      cyc(); quiet(); if_pc = pcs[i]; #1;
      chk("R1", "seq next_pc", next_pc, pcs[i] + 32'd4);
      chk("R1", "no flush", {pc_sel, flush_if, flush_id}, 0);
    end
  endtask

  task automatic t_taken_eq();
    cyc(); quiet(); if_pc = 32'h108;
    put_br(1'b0, 32'd5, 32'd5, 32'h100, 16'h0010); id_reg_we = 1; id_mem_we = 1; #1;
    chk("R4", "pc_sel", pc_sel, 1);
    chk("R4", "flush pair", {flush_if, flush_id}, 2'b11);
    chk("R3", "target", next_pc, exp_tgt(32'h100, 16'h0010));
    chk("R7", "we in redirect cycle", {ex_reg_we, ex_mem_we}, 0);
    cyc(); quiet(); id_reg_we = 1; id_mem_we = 1; #1;
    chk("R7", "we cycle after", {ex_reg_we, ex_mem_we}, 0);
    cyc(); quiet(); id_reg_we = 1; id_mem_we = 1; #1;
    chk("R7", "we recovered", {ex_reg_we, ex_mem_we}, 2'b11);
    idle(3);
  endtask

  task automatic t_ne_neg();
    cyc(); quiet(); if_pc = 32'h2008;
    put_br(1'b1, 32'd1, 32'd2, 32'h2000, 16'hFFFC); #1;
    chk("R2", "ne taken", pc_sel, 1);
    chk("R3", "negative target", next_pc, exp_tgt(32'h2000, 16'hFFFC));
    idle(3);
    cyc(); quiet(); if_pc = 32'h300;
    put_br(1'b0, 32'd1, 32'd2, 32'h2F8, 16'h8); #1;
    chk("R2", "eq unequal not taken", pc_sel, 0);
    chk("R6", "no flush", {flush_if, flush_id}, 0);
    cyc(); quiet(); if_pc = 32'h304;
    put_br(1'b1, 32'd9, 32'd9, 32'h2FC, 16'h8); #1;
    chk("R2", "ne equal not taken", pc_sel, 0);
    chk("R1", "seq after not taken", next_pc, 32'h308);
  endtask

  task automatic t_not_taken();
    idle(3);
    cyc(); quiet(); put_br(1'b0, 32'd3, 32'd4, 32'h500, 16'h10); #1;
    chk("R6", "not taken no flush", {pc_sel, flush_if, flush_id}, 0);
    cyc(); quiet(); put_br(1'b0, 32'd3, 32'd3, 32'h504, 16'h10); #1;
    chk("R6", "next branch redirects", pc_sel, 1);
    idle(3);
  endtask

  task automatic t_penalty();
    cyc(); quiet(); put_br(1'b0, 32'd0, 32'd0, 32'h600, 16'h20); #1;
    chk("R5", "first redirect", pc_sel, 1);
    for (int i = 1; i <= 2; i++) begin
      cyc(); quiet(); put_br(1'b0, 32'd0, 32'd0, 32'h700, 16'h20); #1;
      chk("R5", "squashed slot no redirect", pc_sel, 0);
    end
    cyc(); quiet(); put_br(1'b0, 32'd0, 32'd0, 32'h700, 16'h20); #1;
    chk("R5", "third cycle redirects", pc_sel, 1);
    idle(3);
  endtask

  task automatic t_stall_prio();
    cyc(); quiet(); stall_req = 1; #1;
    chk("R9", "stall alone", {stall_out, pc_en}, 2'b10);
    cyc(); quiet(); idle(3);
    cyc(); quiet(); stall_req = 1; put_br(1'b1, 32'd1, 32'd0, 32'h800, 16'h40); #1;
    chk("R8", "stall_out suppressed", stall_out, 0);
    chk("R8", "pc_en", pc_en, 1);
    chk("R8", "target wins", next_pc, exp_tgt(32'h800, 16'h40));
    idle(3);
  endtask

  task automatic t_stall_bubble();
    cyc(); quiet(); stall_req = 1; #1;
    cyc(); quiet(); put_br(1'b0, 32'd2, 32'd2, 32'h900, 16'h4); id_reg_we = 1; #1;
    chk("R9", "bubble cannot redirect", pc_sel, 0);
    chk("R9", "decode kept live", ex_reg_we, 1);
    cyc(); quiet(); put_br(1'b0, 32'd2, 32'd2, 32'h904, 16'h4); #1;
    chk("R9", "held instr redirects", pc_sel, 1);
    idle(3);
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_seq();
    t_taken_eq();
    t_ne_neg();
    t_not_taken();
    t_penalty();
    t_stall_prio();
    t_stall_bubble();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule